// File: doc/BRIEF.md
# Systolic 4x4 SAD Array

This block scores one 4x4 block of current-frame pixels against several candidate positions in a stream of search-window pixels. It is built from rows of four pixel processing elements. Each element takes the absolute difference of one pixel pair, adds it to the partial sum handed on by its upstream neighbour, and passes the new sum downstream. Each element's pixel pair is delayed by its position in the row, so a column's partial sum and the element's pixels stay in step. An accumulator at the end of each row folds the four column sums into the SAD of one candidate.

The current block is streamed in as four column words on consecutive cycles. The search window is streamed as one column word per cycle from two broadcast strips. Row r receives the current columns r cycles late. Row r therefore matches the block against the search columns that arrive on cycles r to r+3 of the block, so the rows evaluate neighbouring horizontal offsets concurrently. Each row chooses its search strip with its own select bit. The rows finish on consecutive cycles, so their results share one output port. A minimum tracker keeps the smallest SAD of the block and the index of the row that produced it.

Top module: `sad_sys_array`

## Requirements
- R1: While rst_ni is low: sad_vld_o=0, blk_done_o=0, best_sad_o=4095 (all ones) and best_idx_o=0.
- R2: Each 32-bit word carries four 8-bit unsigned pixels, with pixel k in bits [8k+7:8k]. Pixel k is row k of a block column. A pulse on start_i marks column 0 of a block, and columns 1, 2 and 3 follow on the next three cycles.
- R3: The SAD is the sum over all 16 pixel pairs of (larger minus smaller). It is 12 bits wide and reaches 4080 without wrapping.
- R4: Candidate r (0..3) compares block column j with the search word presented j+r cycles after the start cycle.
- R5: For candidate r, strip_sel_i[r]=1 selects srch_b_i and 0 selects srch_a_i. The strip that is not selected has no effect on that candidate.
- R6: Call the start cycle cycle 0. Candidate r's result is on sad_o, with sad_vld_o=1 and cand_idx_o=r, during cycle 8+r only. In every other cycle sad_vld_o is 0.
- R7: The result of candidate 0 reloads the tracker unconditionally. A later candidate replaces the best only if its SAD is strictly smaller, so equal SADs keep the lower index. best_sad_o and best_idx_o change one cycle after the result.
- R8: blk_done_o is high during cycle 12 only, and best_sad_o and best_idx_o then hold the block's minimum.
- R9: Blocks started every 4 cycles produce results on consecutive cycles without mixing data between blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks column 0 of a current block |
| cur_col_i | input | 32 | Current-block column word |
| srch_a_i | input | 32 | Search strip A column word |
| srch_b_i | input | 32 | Search strip B column word |
| strip_sel_i | input | 4 | Per-candidate strip select (1 = B) |
| sad_o | output | 12 | SAD of the candidate being reported |
| sad_vld_o | output | 1 | sad_o and cand_idx_o are valid |
| cand_idx_o | output | 2 | Candidate index of sad_o |
| best_sad_o | output | 12 | Smallest SAD of the block so far |
| best_idx_o | output | 2 | Candidate index of best_sad_o |
| blk_done_o | output | 1 | Best outputs are final for the block |

## Verification
Random blocks are mixed with both signs of pixel difference. A search window that repeats the block at offset 2 must yield a zero SAD at exactly that candidate; this shows up any misalignment of the row delays or of the element skew. An all-255 block against an all-zero window checks the 4080 ceiling, and because every candidate then has the same SAD it also checks that ties keep index 0. Falling and rising SAD profiles show whether the tracker replaces or holds its best. Crossed strip-select patterns and two blocks run back to back check that each row uses only its own strip and its own block.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } tag_t;
endpackage

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 8,
  parameter int STAGE = 0,
  parameter int SUM_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] cur_i,
  input  logic [PIX_W-1:0] ref_i,
  input  logic [SUM_W-1:0] psum_i,
  output logic [SUM_W-1:0] psum_o
);
  localparam int unsigned PIX_MAX = (1 << PIX_W) - 1;
  localparam int unsigned LIM     = (STAGE + 1) * PIX_MAX;

  logic [PIX_W-1:0] cur_d, ref_d, ad;
  logic [SUM_W-1:0] psum_q;

  // skew the pixel pair so it meets the partial sum of the same column
  if (STAGE == 0) begin : g_noskew
    assign cur_d = cur_i;
    assign ref_d = ref_i;
  end else begin : g_skew
    logic [PIX_W-1:0] cur_sr [STAGE];
    logic [PIX_W-1:0] ref_sr [STAGE];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < STAGE; i++) begin
          cur_sr[i] <= '0;
          ref_sr[i] <= '0;
        end
      end else begin
        cur_sr[0] <= cur_i;
        ref_sr[0] <= ref_i;
        for (int i = 1; i < STAGE; i++) begin
          cur_sr[i] <= cur_sr[i-1];
          ref_sr[i] <= ref_sr[i-1];
        end
      end
    end
    assign cur_d = cur_sr[STAGE-1];
    assign ref_d = ref_sr[STAGE-1];
  end

  assign ad = (cur_d > ref_d) ? (cur_d - ref_d) : (ref_d - cur_d);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) psum_q <= '0;
    else         psum_q <= psum_i + SUM_W'(ad);
  end

  assign psum_o = psum_q;

  // R3: partial sum never exceeds (stage+1) full-scale differences
  a_r3_pe_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psum_q <= SUM_W'(LIM));
endmodule

// File: rtl/sad_row.sv
module sad_row
  import sad_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int N_PIX   = 4,
  parameter int ROW_IDX = 0,
  parameter int SUM_W   = 10,
  parameter int SAD_W   = 12
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_PIX*PIX_W-1:0] cur_i,
  input  tag_t                   tag_i,
  input  logic [N_PIX*PIX_W-1:0] srch_a_i,
  input  logic [N_PIX*PIX_W-1:0] srch_b_i,
  input  logic                   sel_i,
  output logic [SAD_W-1:0]       sad_o,
  output logic                   vld_o
);
  localparam int WORD_W = N_PIX * PIX_W;
  localparam int unsigned SAD_MAX = N_PIX * N_PIX * ((1 << PIX_W) - 1);

  logic [WORD_W-1:0] cur_d, ref_w;
  tag_t              tag_d, tag_e;
  logic [SUM_W-1:0]  ps [N_PIX+1];
  logic [SAD_W-1:0]  acc_q, acc_nxt;
  logic              vld_q;

  // row offset: current columns arrive ROW_IDX cycles late
  if (ROW_IDX == 0) begin : g_nodly
    assign cur_d = cur_i;
    assign tag_d = tag_i;
  end else begin : g_dly
    logic [WORD_W-1:0] cur_sr [ROW_IDX];
    tag_t              tag_sr [ROW_IDX];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < ROW_IDX; i++) begin
          cur_sr[i] <= '0;
          tag_sr[i] <= '0;
        end
      end else begin
        cur_sr[0] <= cur_i;
        tag_sr[0] <= tag_i;
        for (int i = 1; i < ROW_IDX; i++) begin
          cur_sr[i] <= cur_sr[i-1];
          tag_sr[i] <= tag_sr[i-1];
        end
      end
    end
    assign cur_d = cur_sr[ROW_IDX-1];
    assign tag_d = tag_sr[ROW_IDX-1];
  end

  assign ref_w = sel_i ? srch_b_i : srch_a_i;
  assign ps[0] = '0;

  for (genvar k = 0; k < N_PIX; k++) begin : g_pe
    sad_pe #(.PIX_W(PIX_W), .STAGE(k), .SUM_W(SUM_W)) u_pe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cur_i  (cur_d[k*PIX_W +: PIX_W]),
      .ref_i  (ref_w[k*PIX_W +: PIX_W]),
      .psum_i (ps[k]),
      .psum_o (ps[k+1])
    );
  end

  // tag follows the column sum through the chain
  tag_t tag_pl [N_PIX];
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PIX; i++) tag_pl[i] <= '0;
    end else begin
      tag_pl[0] <= tag_d;
      for (int i = 1; i < N_PIX; i++) tag_pl[i] <= tag_pl[i-1];
    end
  end
  assign tag_e = tag_pl[N_PIX-1];

  assign acc_nxt = tag_e.first ? SAD_W'(ps[N_PIX]) : acc_q + SAD_W'(ps[N_PIX]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (tag_e.vld) acc_q <= acc_nxt;
      vld_q <= tag_e.vld & tag_e.last;
    end
  end

  assign sad_o = acc_q;
  assign vld_o = vld_q;

  // R3: a finished SAD stays within 16 full-scale differences
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> (acc_q <= SAD_W'(SAD_MAX)));
endmodule

// File: rtl/sad_min_track.sv
module sad_min_track #(
  parameter int SAD_W  = 12,
  parameter int IDX_W  = 2,
  parameter int N_ROWS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [SAD_W-1:0] sad_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [SAD_W-1:0] best_sad_o,
  output logic [IDX_W-1:0] best_idx_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_ROWS - 1);

  logic [SAD_W-1:0] best_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      best_q <= '1;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      // candidate 0 opens a new block
      if (vld_i && (idx_i == '0 || sad_i < best_q)) begin
        best_q <= sad_i;
        idx_q  <= idx_i;
      end
      done_q <= vld_i && (idx_i == LAST_IDX);
    end
  end

  assign best_sad_o = best_q;
  assign best_idx_o = idx_q;
  assign done_o     = done_q;

  // R7: first candidate reloads the tracker
  a_r7_first_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i == '0) |=> (best_q == $past(sad_i)));
  // R7: later candidates never raise the best
  a_r7_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && idx_i != '0) |=> (best_q <= $past(best_q) && best_q <= $past(sad_i)));
  // R8: done only right after the last candidate
  a_r8_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(vld_i && idx_i == LAST_IDX));
endmodule

// File: rtl/sad_sys_array.sv
module sad_sys_array
  import sad_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int N_PIX  = 4,
  parameter int N_ROWS = 4,
  localparam int WORD_W = N_PIX * PIX_W,
  localparam int SAD_W  = PIX_W + $clog2(N_PIX * N_PIX),
  localparam int IDX_W  = (N_ROWS > 1) ? $clog2(N_ROWS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cur_col_i,
  input  logic [WORD_W-1:0] srch_a_i,
  input  logic [WORD_W-1:0] srch_b_i,
  input  logic [N_ROWS-1:0] strip_sel_i,
  output logic [SAD_W-1:0]  sad_o,
  output logic              sad_vld_o,
  output logic [IDX_W-1:0]  cand_idx_o,
  output logic [SAD_W-1:0]  best_sad_o,
  output logic [IDX_W-1:0]  best_idx_o,
  output logic              blk_done_o
);
  localparam int SUM_W = PIX_W + $clog2(N_PIX);
  localparam int COL_W = (N_PIX > 1) ? $clog2(N_PIX) : 1;
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(N_PIX - 1);

  logic             busy_q;
  logic [COL_W-1:0] col_q, col_cur;
  tag_t             tag_in;

  // column sequencer: start marks column 0, the rest follow
  assign col_cur = start_i ? '0 : col_q;
  assign tag_in  = '{vld: start_i | busy_q, first: col_cur == '0, last: col_cur == LAST_COL};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      col_q  <= '0;
    end else if (start_i || busy_q) begin
      busy_q <= (col_cur != LAST_COL);
      col_q  <= col_cur + COL_W'(1);
    end
  end

  logic [SAD_W-1:0]  row_sad [N_ROWS];
  logic [N_ROWS-1:0] row_vld;

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    sad_row #(
      .PIX_W(PIX_W), .N_PIX(N_PIX), .ROW_IDX(r), .SUM_W(SUM_W), .SAD_W(SAD_W)
    ) u_row (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cur_i    (cur_col_i),
      .tag_i    (tag_in),
      .srch_a_i (srch_a_i),
      .srch_b_i (srch_b_i),
      .sel_i    (strip_sel_i[r]),
      .sad_o    (row_sad[r]),
      .vld_o    (row_vld[r])
    );
  end

  // rows finish on distinct cycles, so an OR mux suffices
  logic [SAD_W-1:0] sad_mux;
  logic [IDX_W-1:0] idx_mux;
  always_comb begin
    sad_mux = '0;
    idx_mux = '0;
    for (int r = 0; r < N_ROWS; r++) begin
      if (row_vld[r]) begin
        sad_mux = sad_mux | row_sad[r];
        idx_mux = idx_mux | IDX_W'(r);
      end
    end
  end

  assign sad_o      = sad_mux;
  assign sad_vld_o  = |row_vld;
  assign cand_idx_o = idx_mux;

  sad_min_track #(.SAD_W(SAD_W), .IDX_W(IDX_W), .N_ROWS(N_ROWS)) u_min (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (sad_vld_o),
    .sad_i      (sad_mux),
    .idx_i      (idx_mux),
    .best_sad_o (best_sad_o),
    .best_idx_o (best_idx_o),
    .done_o     (blk_done_o)
  );

  // R6: at most one row reports per cycle
  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_vld));

  // R6: row r+1 reports the cycle after row r
  for (genvar r = 0; r < N_ROWS - 1; r++) begin : g_stagger
    a_r6_row_stagger: assert property (@(posedge clk_i) disable iff (!rst_ni)
      row_vld[r] |=> row_vld[r+1]);
  end
endmodule

// File: tb/sim_sad_sys_array.sv
module sim_sad_sys_array;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] cur_col_i = '0, srch_a_i = '0, srch_b_i = '0;
  logic [3:0]  strip_sel_i = '0;
  logic [11:0] sad_o, best_sad_o;
  logic        sad_vld_o, blk_done_o;
  logic [1:0]  cand_idx_o, best_idx_o;

  always #2 clk = ~clk;

  sad_sys_array u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cur_col_i(cur_col_i),
    .srch_a_i(srch_a_i), .srch_b_i(srch_b_i), .strip_sel_i(strip_sel_i),
    .sad_o(sad_o), .sad_vld_o(sad_vld_o), .cand_idx_o(cand_idx_o),
    .best_sad_o(best_sad_o), .best_idx_o(best_idx_o), .blk_done_o(blk_done_o)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] cur_px [2][4][4];   // block, column, pixel
  logic [7:0] sa [12][4];
  logic [7:0] sb [12][4];
  logic [3:0] selb [2];

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] p0, p1, p2, p3);
    return {p3, p2, p1, p0};
  endfunction

  task automatic fill_rand();
    for (int b = 0; b < 2; b++) begin
      selb[b] = '0;
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 4; k++) cur_px[b][j][k] = 8'($urandom);
    end
    for (int c = 0; c < 12; c++)
      for (int k = 0; k < 4; k++) begin
        sa[c][k] = 8'($urandom);
        sb[c][k] = 8'($urandom);
      end
  endtask

  task automatic idle();
    start_i = 0; cur_col_i = '0; srch_a_i = '0; srch_b_i = '0; strip_sel_i = '0;
  endtask

  task automatic do_reset();
    rst_ni = 0;
    idle();
    repeat (3) @(negedge clk);
    chk(sad_vld_o == 0, "R1 reset sad_vld_o", int'(sad_vld_o), 0);
    chk(blk_done_o == 0, "R1 reset blk_done_o", int'(blk_done_o), 0);
    chk(best_sad_o == 12'hfff, "R1 reset best_sad_o", int'(best_sad_o), 4095);
    chk(best_idx_o == 0, "R1 reset best_idx_o", int'(best_idx_o), 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
  endtask

  // runs nb blocks started every 4 cycles and checks every output cycle
  task automatic run_blocks(input int nb, input string lbl);
    int exp_sad [2][4];
    int run_min [2][4];
    int run_idx [2][4];
    int total;
    for (int b = 0; b < nb; b++) begin
      for (int r = 0; r < 4; r++) begin
        int s = 0;
        for (int j = 0; j < 4; j++)
          for (int k = 0; k < 4; k++) begin
            int c = 4*b + r + j;
            int rv = selb[b][r] ? int'(sb[c][k]) : int'(sa[c][k]);
            int cv = int'(cur_px[b][j][k]);
            s += (cv > rv) ? cv - rv : rv - cv;
          end
        exp_sad[b][r] = s;
        if (r == 0 || s < run_min[b][r-1]) begin
          run_min[b][r] = s; run_idx[b][r] = r;
        end else begin
          run_min[b][r] = run_min[b][r-1]; run_idx[b][r] = run_idx[b][r-1];
        end
      end
    end
    total = 4*nb + 12;
    for (int cyc = 0; cyc <= total; cyc++) begin
      bit exp_vld = 0, exp_done = 0;
      int eb = 0, er = 0;
      @(negedge clk);
      // sample: outputs belonging to cycle cyc
      for (int b = 0; b < nb; b++) begin
        for (int r = 0; r < 4; r++)
          if (cyc == 4*b + 8 + r) begin exp_vld = 1; eb = b; er = r; end
        if (cyc == 4*b + 12) exp_done = 1;
      end
      chk(sad_vld_o == exp_vld, $sformatf("%s R6 sad_vld_o cycle %0d", lbl, cyc),
          int'(sad_vld_o), int'(exp_vld));
      if (exp_vld) begin
        chk(cand_idx_o == er, $sformatf("%s R6 cand_idx_o cycle %0d", lbl, cyc),
            int'(cand_idx_o), er);
        chk(sad_o == exp_sad[eb][er], $sformatf("%s R3/R4 sad blk %0d cand %0d", lbl, eb, er),
            int'(sad_o), exp_sad[eb][er]);
      end
      chk(blk_done_o == exp_done, $sformatf("%s R8 blk_done_o cycle %0d", lbl, cyc),
          int'(blk_done_o), int'(exp_done));
      for (int b = 0; b < nb; b++)
        for (int r = 0; r < 4; r++)
          if (cyc == 4*b + 9 + r) begin
            chk(best_sad_o == run_min[b][r], $sformatf("%s R7 best_sad blk %0d after cand %0d", lbl, b, r),
                int'(best_sad_o), run_min[b][r]);
            chk(best_idx_o == run_idx[b][r], $sformatf("%s R7 best_idx blk %0d after cand %0d", lbl, b, r),
                int'(best_idx_o), run_idx[b][r]);
          end
      // drive: inputs of cycle cyc
      start_i   = (cyc < 4*nb) && (cyc % 4 == 0);
      cur_col_i = (cyc < 4*nb) ? pack4(cur_px[cyc/4][cyc%4][0], cur_px[cyc/4][cyc%4][1],
                                       cur_px[cyc/4][cyc%4][2], cur_px[cyc/4][cyc%4][3]) : '0;
      if (cyc < 4*nb + 3) begin
        srch_a_i = pack4(sa[cyc][0], sa[cyc][1], sa[cyc][2], sa[cyc][3]);
        srch_b_i = pack4(sb[cyc][0], sb[cyc][1], sb[cyc][2], sb[cyc][3]);
      end else begin
        srch_a_i = '0; srch_b_i = '0;
      end
      for (int r = 0; r < 4; r++) begin
        int b = (cyc >= r) ? (cyc - r) / 4 : 0;
        if (b > nb - 1) b = nb - 1;
        strip_sel_i[r] = selb[b][r];
      end
    end
    idle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_random();
    fill_rand();
    run_blocks(1, "R2 random block");
  endtask

  task automatic t_max();
    fill_rand();
    for (int j = 0; j < 4; j++) for (int k = 0; k < 4; k++) cur_px[0][j][k] = 8'd255;
    for (int c = 0; c < 12; c++) for (int k = 0; k < 4; k++) begin sa[c][k] = 0; sb[c][k] = 8'd255; end
    run_blocks(1, "R3 full-scale ties");
  endtask

  task automatic t_match();
    fill_rand();
    for (int j = 0; j < 4; j++) for (int k = 0; k < 4; k++) sa[2+j][k] = cur_px[0][j][k];
    run_blocks(1, "R4 exact match at offset 2");
  endtask

  task automatic t_strip();
    fill_rand();
    selb[0] = 4'b1010;
    run_blocks(1, "R5 strip select 1010");
    selb[0] = 4'b0101;
    for (int c = 0; c < 12; c++) for (int k = 0; k < 4; k++) sb[c][k] = 8'($urandom);
    run_blocks(1, "R5 strip select 0101");
  endtask

  task automatic t_profile();
    fill_rand();
    for (int j = 0; j < 4; j++) for (int k = 0; k < 4; k++) cur_px[0][j][k] = 0;
    for (int c = 0; c < 7; c++) for (int k = 0; k < 4; k++) sa[c][k] = 8'(60 - 10*c);
    run_blocks(1, "R7 falling SADs");
    for (int c = 0; c < 7; c++) for (int k = 0; k < 4; k++) sa[c][k] = 8'(10*c);
    run_blocks(1, "R7 rising SADs");
  endtask

  task automatic t_b2b();
    fill_rand();
    selb[0] = 4'b0011;
    selb[1] = 4'b1100;
    run_blocks(2, "R9 back-to-back");
  endtask

  initial begin
    do_reset();
    t_random();
    t_random();
    t_max();
    t_match();
    t_strip();
    t_profile();
    t_b2b();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule